// File: doc/BRIEF.md
# Shift-Register Clock Divider with Post-Divide

This block produces the divided clock enables around a frequency synthesiser. A reference divider (6 bits) and a feedback divider (8 bits) each keep their count in a shift register with XNOR feedback, not in a binary counter. The register shifts left once per enabled cycle, and the feedback bit enters at the least significant position. The all-ones word is the terminal state. The shift alone never reaches it: the all-zero word steps straight to all-ones. In the cycle after the terminal state the register takes the software reload word, a one-cycle tick is issued and a half-rate output toggles. To divide by N, software writes the sequence state that lies N-1 steps before the terminal state. Loading all-ones therefore divides by one.

A two-stage post-divider counts the synthesiser-side enable. Each stage divides by a ratio from 1 to 8. The two ratios are packed into one 6-bit word, and each field holds 8 minus its ratio. The output period in synthesiser-side cycles is the product of the two ratios. Software uses the reference divider in the range 3 to 40, the feedback divider in the range 5 to 256, and keeps the second ratio no larger than the first. The hardware itself accepts every code.

All three settings are written through one narrow write port. A new value is held in a register and is used only at the owning divider's next terminal point, so a count already in progress is never cut short or stretched.

Top module: `lfsr_clk_divider`

## Requirements
- R1: After reset all tick and half-rate outputs are low, both reload words are all-ones (divide by 1) and the post-divide code is 6'h3f (1 x 1). With both enables held high, every tick output is high in the first cycle after enabling.
- R2: Reference divider: a 6-bit left shift with feedback XNOR(bit5, bit4) into bit 0, and 0x00 steps to the terminal 0x3f. Reload 0x3f gives divide-by-1, 0x00 gives 2, 0x20 gives 3, 0x3d gives 58 and 0x01 gives 64. Every reload value divides by its distance to 0x3f plus one.
- R3: Feedback divider: an 8-bit left shift with feedback XNOR(bit7, bit3, bit2, bit1) into bit 0, and 0x00 steps to the terminal 0xff. Reload 0x00 gives divide-by-2, 0x80 gives 3 and 0x01 gives 256. Every value from 2 to 256 is reachable.
- R4: A tick is a single-cycle pulse in the cycle after the enabled cycle in which the register held the terminal state. Successive ticks are N enabled cycles apart.
- R5: Each half-rate output toggles exactly in the cycles in which its tick is high, so it stays level for N enabled cycles.
- R6: While a divider's enable is low its state is frozen and it issues no tick. An alternating enable doubles the tick period in clock cycles.
- R7: A reload write changes no count in progress; the new word is loaded at the next terminal state. A write accepted at the same clock edge as a terminal reload leaves that reload with the old word, so one more old period follows before the new one.
- R8: Post-divide code bits [5:3] hold 8-pd1 and bits [2:0] hold 8-pd2. The post tick repeats every pd1*pd2 synthesiser-side enables, and each stage picks up a new ratio only at its own terminal count.
- R9: cfg_sel 0 writes the reference reload from cfg_wdata[5:0] (bits 7:6 are ignored), 1 writes the feedback reload from cfg_wdata[7:0], 2 writes the post code from cfg_wdata[5:0], and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the setting selected by cfg_sel |
| cfg_sel | input | 2 | Setting select: 0 reference reload, 1 feedback reload, 2 post code, 3 none |
| cfg_wdata | input | 8 | Write data |
| ref_ce | input | 1 | Step enable of the reference divider |
| vco_ce | input | 1 | Step enable of the feedback divider and the post-divider |
| ref_tick | output | 1 | Reference divider terminal pulse |
| ref_half | output | 1 | Reference half-rate output |
| fb_tick | output | 1 | Feedback divider terminal pulse |
| fb_half | output | 1 | Feedback half-rate output |
| post_tick | output | 1 | Post-divider output pulse |

## Verification
A software reload write and a terminal-state reload can land on the same clock edge. In that case the reload register changes while the shift register is already taking the word out of it. The bench locks onto a tick of a divide-by-7 setting and times a write of a divide-by-4 word so that it is accepted exactly at the next terminal edge. It then requires that tick to appear, the next interval to be 7 and the one after it to be 4. A write in the middle of a count is also checked: it must leave the current interval at its old length.

// File: rtl/lfsr_clkdiv_pkg.sv
package lfsr_clkdiv_pkg;

  // divider widths and their feedback tap masks (bit set = bit taken into the XNOR)
  localparam int          REF_BITS     = 6;
  localparam int          FB_BITS      = 8;
  localparam logic [5:0]  REF_TAP_MASK = 6'h30;
  localparam logic [7:0]  FB_TAP_MASK  = 8'h8e;
  localparam int          POST_FIELD   = 3;
  localparam int          POST_STAGES  = 2;

  typedef enum logic [1:0] {
    SEL_REF  = 2'd0,
    SEL_FB   = 2'd1,
    SEL_POST = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/lfsr_cfg_regs.sv
module lfsr_cfg_regs
  import lfsr_clkdiv_pkg::*;
#(
  parameter int REF_W = 6,
  parameter int FB_W  = 8,
  parameter int PC_W  = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  output logic [REF_W-1:0] ref_reload_o,
  output logic [FB_W-1:0]  fb_reload_o,
  output logic [PC_W-1:0]  post_code_o
);

  logic [REF_W-1:0] ref_q;
  logic [FB_W-1:0]  fb_q;
  logic [PC_W-1:0]  post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '1;
      fb_q   <= '1;
      post_q <= '1;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_REF:  ref_q  <= wdata[REF_W-1:0];
        SEL_FB:   fb_q   <= wdata[FB_W-1:0];
        SEL_POST: post_q <= wdata[PC_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ref_reload_o = ref_q;
  assign fb_reload_o  = fb_q;
  assign post_code_o  = post_q;

endmodule

// File: rtl/lfsr_divider.sv
module lfsr_divider #(
  parameter int             W    = 6,
  parameter logic [W-1:0]   TAPS = 6'h30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] state_o,
  output logic         term_o,
  output logic         tick_o,
  output logic         half_o
);

  localparam logic [W-1:0] TERM = '1;

  // one step of the sequence; the all-zero word jumps to the terminal word
  function automatic logic [W-1:0] seq_step(input logic [W-1:0] s);
    if (s == '0) return TERM;
    return {s[W-2:0], ~(^(s & TAPS))};
  endfunction

  logic [W-1:0] state_q;
  logic         tick_q;
  logic         half_q;
  logic         wrap;

  assign term_o = (state_q == TERM);
  assign wrap   = ce && term_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TERM;
      tick_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (wrap) half_q <= ~half_q;
      if (ce)   state_q <= term_o ? reload_i : seq_step(state_q);
    end
  end

  assign state_o = state_q;
  assign tick_o  = tick_q;
  assign half_o  = half_q;

endmodule

// File: rtl/post_div_stage.sv
module post_div_stage #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [FW-1:0] code_i,
  output logic          evt_o
);

  localparam int LW = FW + 1;

  // a field holds (2**FW - ratio)
  function automatic logic [LW-1:0] ratio_of(input logic [FW-1:0] c);
    logic [LW-1:0] full;
    full = LW'(1) << FW;
    return full - {1'b0, c};
  endfunction

  logic [FW-1:0] cnt_q;
  logic [LW-1:0] lim_q;

  assign evt_o = ce && ({1'b0, cnt_q} == (lim_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LW'(1);
    end else if (evt_o) begin
      cnt_q <= '0;
      lim_q <= ratio_of(code_i);
    end else if (ce) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lfsr_clk_divider.sv
module lfsr_clk_divider
  import lfsr_clkdiv_pkg::*;
#(
  parameter int                 REF_W    = REF_BITS,
  parameter int                 FB_W     = FB_BITS,
  parameter logic [REF_W-1:0]   REF_TAPS = REF_TAP_MASK,
  parameter logic [FB_W-1:0]    FB_TAPS  = FB_TAP_MASK,
  parameter int                 PF_W     = POST_FIELD,
  parameter int                 NSTAGE   = POST_STAGES,
  parameter int                 DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ref_ce,
  input  logic          vco_ce,
  output logic          ref_tick,
  output logic          ref_half,
  output logic          fb_tick,
  output logic          fb_half,
  output logic          post_tick
);

  localparam int PC_W = NSTAGE * PF_W;

  // named internal events, also watched by the checker
  logic [REF_W-1:0] ref_reload_w;
  logic [FB_W-1:0]  fb_reload_w;
  logic [PC_W-1:0]  post_code_w;
  logic [REF_W-1:0] ref_state_w;
  logic [FB_W-1:0]  fb_state_w;
  logic             ref_term_w;
  logic             fb_term_w;
  logic [NSTAGE-1:0] stage_ce_w;
  logic [NSTAGE-1:0] stage_evt_w;
  logic             post_q;

  lfsr_cfg_regs #(
    .REF_W(REF_W), .FB_W(FB_W), .PC_W(PC_W), .DW(DW)
  ) i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .sel          (cfg_sel),
    .wdata        (cfg_wdata),
    .ref_reload_o (ref_reload_w),
    .fb_reload_o  (fb_reload_w),
    .post_code_o  (post_code_w)
  );

  lfsr_divider #(.W(REF_W), .TAPS(REF_TAPS)) i_ref_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ref_ce),
    .reload_i (ref_reload_w),
    .state_o  (ref_state_w),
    .term_o   (ref_term_w),
    .tick_o   (ref_tick),
    .half_o   (ref_half)
  );

  lfsr_divider #(.W(FB_W), .TAPS(FB_TAPS)) i_fb_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (vco_ce),
    .reload_i (fb_reload_w),
    .state_o  (fb_state_w),
    .term_o   (fb_term_w),
    .tick_o   (fb_tick),
    .half_o   (fb_half)
  );

  // post-divide chain: stage 0 takes the upper field, each later stage the next one down
  for (genvar g = 0; g < NSTAGE; g++) begin : g_post
    if (g == 0) begin : g_first
      assign stage_ce_w[g] = vco_ce;
    end else begin : g_next
      assign stage_ce_w[g] = stage_evt_w[g-1];
    end
    post_div_stage #(.FW(PF_W)) i_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce     (stage_ce_w[g]),
      .code_i (post_code_w[(NSTAGE-1-g)*PF_W +: PF_W]),
      .evt_o  (stage_evt_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_q <= 1'b0;
    else        post_q <= stage_evt_w[NSTAGE-1];
  end

  assign post_tick = post_q;

endmodule

// File: rtl/lfsr_clk_divider_chk.sv
module lfsr_clk_divider_chk #(
  parameter int REF_W = 6,
  parameter int FB_W  = 8,
  parameter int PC_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic             ref_ce,
  input logic             vco_ce,
  input logic             ref_tick,
  input logic             ref_half,
  input logic             fb_tick,
  input logic             fb_half,
  input logic             post_tick,
  input logic [REF_W-1:0] ref_state,
  input logic [FB_W-1:0]  fb_state,
  input logic             ref_term,
  input logic             fb_term,
  input logic [REF_W-1:0] ref_reload,
  input logic [FB_W-1:0]  fb_reload,
  input logic [PC_W-1:0]  post_code
);

  // R2
  ref_zero_to_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ce && ref_state == '0) |=> ref_term);

  // R3
  fb_zero_to_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_ce && fb_state == '0) |=> fb_term);

  // R4
  ref_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> ($past(ref_ce) && $past(ref_term)));

  // R5
  ref_half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> (ref_half != $past(ref_half)));

  // R5
  fb_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_tick |-> (fb_half == $past(fb_half)));

  // R6
  ref_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ce |=> ($stable(ref_state) && !ref_tick));

  // R7
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ce && ref_term) |=> (ref_state == $past(ref_reload)));

  // R7
  fb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_ce && fb_term) |=> (fb_state == $past(fb_reload)));

  // R8
  post_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_tick |-> $past(vco_ce));

  // R9
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=>
      ($stable(ref_reload) && $stable(fb_reload) && $stable(post_code)));

endmodule

bind lfsr_clk_divider lfsr_clk_divider_chk #(
  .REF_W(REF_W), .FB_W(FB_W), .PC_W(PC_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .ref_ce     (ref_ce),
  .vco_ce     (vco_ce),
  .ref_tick   (ref_tick),
  .ref_half   (ref_half),
  .fb_tick    (fb_tick),
  .fb_half    (fb_half),
  .post_tick  (post_tick),
  .ref_state  (ref_state_w),
  .fb_state   (fb_state_w),
  .ref_term   (ref_term_w),
  .fb_term    (fb_term_w),
  .ref_reload (ref_reload_w),
  .fb_reload  (fb_reload_w),
  .post_code  (post_code_w)
);

// File: tb/test_lfsr_clk_divider.sv
`timescale 1ns/1ps
module test_lfsr_clk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       ref_ce = 1'b0;
  logic       vco_ce = 1'b0;
  logic       ref_tick, ref_half, fb_tick, fb_half, post_tick;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lfsr_clk_divider i_lfsr_clk_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ref_ce    (ref_ce),
    .vco_ce    (vco_ce),
    .ref_tick  (ref_tick),
    .ref_half  (ref_half),
    .fb_tick   (fb_tick),
    .fb_half   (fb_half),
    .post_tick (post_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sequence model: the reload word for divide-by-n is reached from 0x01 after (2**w - n) steps
  function automatic int reload_for(input int w, input int taps, input int n);
    int s, mask;
    mask = (1 << w) - 1;
    s = 1;
    for (int j = 0; j < (1 << w) - n; j++) begin
      if (s == 0) s = mask;
      else s = ((s << 1) & mask) | ((($countones(s & taps) % 2) == 0) ? 1 : 0);
    end
    return s;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic tick_of(input int which);
    case (which)
      0: return ref_tick;
      1: return fb_tick;
      default: return post_tick;
    endcase
  endfunction

  task automatic wait_tick(input int which, output int t);
    t = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (tick_of(which)) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic measure(input int which, output int per);
    int a, b, c;
    wait_tick(which, a);
    wait_tick(which, b);
    wait_tick(which, c);
    per = (a < 0 || b < 0 || c < 0) ? -1 : c - b;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset with enables low
    chk(!ref_tick && !fb_tick && !post_tick, "R1 ticks idle", {ref_tick, fb_tick, post_tick}, 0);
    chk(!ref_half && !fb_half, "R1 halves low", {ref_half, fb_half}, 0);
    ref_ce = 1'b1; vco_ce = 1'b1;
    @(negedge clk);
    // R1: default divide-by-1 everywhere
    chk(ref_tick && fb_tick && post_tick, "R1 first ticks", {ref_tick, fb_tick, post_tick}, 7);
  endtask

  task automatic t_ref_sweep;
    int per;
    for (int n = 1; n <= 64; n++) begin
      cfg_write(2'd0, 8'(reload_for(6, 'h30, n)));
      measure(0, per);
      chk(per == n, "R2 ref divide", per, n); // R2
    end
  endtask

  task automatic t_fb_sweep;
    int per;
    for (int n = 2; n <= 256; n++) begin
      cfg_write(2'd1, 8'(reload_for(8, 'h8e, n)));
      measure(1, per);
      chk(per == n, "R3 fb divide", per, n); // R3
    end
  endtask

  task automatic t_anchors;
    int per;
    cfg_write(2'd0, 8'h20); measure(0, per); chk(per == 3,  "R2 0x20", per, 3);
    cfg_write(2'd0, 8'h3d); measure(0, per); chk(per == 58, "R2 0x3d", per, 58);
    cfg_write(2'd0, 8'h01); measure(0, per); chk(per == 64, "R2 0x01", per, 64);
    cfg_write(2'd1, 8'h00); measure(1, per); chk(per == 2,   "R3 0x00", per, 2);
    cfg_write(2'd1, 8'h80); measure(1, per); chk(per == 3,   "R3 0x80", per, 3);
    cfg_write(2'd1, 8'h01); measure(1, per); chk(per == 256, "R3 0x01", per, 256);
    // R9: bits 7:6 ignored for the reference word, 0x05 divides by 38
    cfg_write(2'd0, 8'hc5); measure(0, per); chk(per == 38, "R9 ref upper bits", per, 38);
  endtask

  task automatic t_pulse_half;
    int t;
    logic h;
    cfg_write(2'd0, 8'h20);
    measure(0, t);
    wait_tick(0, t);
    h = ref_half;
    @(negedge clk);
    chk(!ref_tick, "R4 single-cycle tick", ref_tick, 0);
    chk(ref_half == h, "R5 half held", ref_half, h);
    @(negedge clk);
    chk(!ref_tick && ref_half == h, "R5 half held 2", ref_half, h);
    @(negedge clk);
    chk(ref_tick && ref_half == !h, "R5 half toggles with tick", ref_half, !h);
  endtask

  task automatic t_enable;
    int t0, t1, a, b, c;
    int ticks;
    // R6: freeze for 20 cycles right after a reload of divide-by-10
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 10)));
    measure(0, t0);
    wait_tick(0, t0);
    ref_ce = 1'b0;
    ticks = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ref_tick) ticks++;
    end
    chk(ticks == 0, "R6 no tick while frozen", ticks, 0);
    ref_ce = 1'b1;
    wait_tick(0, t1);
    chk(t1 - t0 == 30, "R6 resume count", t1 - t0, 30);
    // R6: alternating enable with divide-by-5 gives 10-cycle spacing
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 5)));
    a = -1; b = -1; c = -1; ticks = 0;
    for (int k = 0; k < 200 && ticks < 4; k++) begin
      @(negedge clk);
      if (ref_tick) begin
        ticks++;
        a = b; b = c; c = cyc;
      end
      ref_ce = ~ref_ce;
    end
    ref_ce = 1'b1;
    chk(ticks == 4 && (c - b) == 10, "R6 alternating enable", c - b, 10);
  endtask

  task automatic t_reload_timing;
    int t, t2, t3;
    // R7: write lands on the terminal edge
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 7)));
    measure(0, t);
    wait_tick(0, t);
    repeat (6) @(negedge clk);
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 4)));
    chk(ref_tick == 1'b1, "R7 terminal at write edge", ref_tick, 1);
    t = cyc;
    wait_tick(0, t2);
    chk(t2 - t == 7, "R7 old word used on collision", t2 - t, 7);
    wait_tick(0, t3);
    chk(t3 - t2 == 4, "R7 new word after collision", t3 - t2, 4);
    // R7: write in mid-count leaves the running interval alone
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 40)));
    measure(0, t);
    wait_tick(0, t);
    repeat (10) @(negedge clk);
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 5)));
    wait_tick(0, t2);
    chk(t2 - t == 40, "R7 mid-count write", t2 - t, 40);
    wait_tick(0, t3);
    chk(t3 - t2 == 5, "R7 new word after mid-count", t3 - t2, 5);
  endtask

  task automatic t_post;
    int per;
    // R8: code = ((8-pd1) << 3) | (8-pd2)
    cfg_write(2'd2, 8'h2e); measure(2, per); chk(per == 6,  "R8 3x2", per, 6);
    cfg_write(2'd2, 8'h1d); measure(2, per); chk(per == 15, "R8 5x3", per, 15);
    cfg_write(2'd2, 8'h00); measure(2, per); chk(per == 64, "R8 8x8", per, 64);
    cfg_write(2'd2, 8'h3f); measure(2, per); chk(per == 1,  "R8 1x1", per, 1);
    cfg_write(2'd2, 8'h2e); measure(2, per); chk(per == 6,  "R8 back to 3x2", per, 6);
  endtask

  task automatic t_ignore;
    int per;
    cfg_write(2'd0, 8'(reload_for(6, 'h30, 4)));
    cfg_write(2'd1, 8'(reload_for(8, 'h8e, 6)));
    measure(0, per);
    // R9: select 3 writes nothing
    cfg_write(2'd3, 8'h00);
    measure(0, per); chk(per == 4, "R9 ref unchanged", per, 4);
    measure(1, per); chk(per == 6, "R9 fb unchanged", per, 6);
    measure(2, per); chk(per == 6, "R9 post unchanged", per, 6);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_anchors;
    t_pulse_half;
    t_enable;
    t_reload_timing;
    t_post;
    t_ignore;
    t_ref_sweep;
    t_fb_sweep;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule